// File: doc/BRIEF.md
# Output Data Register Bank with Masked Direct Write

This block holds the output level for every line of a 32-line I/O bank and produces the pad drive value and drive enable for each line. Software changes the stored levels in three ways: a set lane that forces selected bits to 1, a clear lane that forces selected bits to 0, and a direct write of the whole data word. The direct write only reaches bits that a separate write-permission mask allows, so one routine can update a field of pins without a read-modify-write and without disturbing pins owned by other code.

Each line can also be put into open-drain mode. An open-drain line only pulls low. When its stored bit is 1, it releases the pad instead of driving it high. The actual pad level comes back through a two-stage synchronizer, and software can read it in a pin-level register.

Top module: `odr_bank`

## Requirements
- R1: After reset the stored data, the write-permission mask and the open-drain status are all zero. `pad_oe` is all ones and `pad_out` is all zeros.
- R2: A cycle with `set_we` high sets every data bit that is 1 in `set_data`. The other bits stay as they were, and the new value is readable at address 0 after the clock edge.
- R3: A cycle with `clr_we` high clears every data bit that is 1 in `clr_data`. The other bits stay as they were.
- R4: When the set lane and the clear lane target the same bit in the same cycle, that bit ends up 0.
- R5: A register write to address 0 (DATA) updates only the data bits whose write-permission status bit is 1. With the mask all zero, the write has no effect.
- R6: Writing address 1 (WM_ON) sets the permission status bits where the write data is 1. Writing address 2 (WM_OFF) clears them. Zero bits leave the status unchanged, and the status reads back at address 3.
- R7: Writing address 4 (OD_ON) sets the open-drain status bits where the write data is 1. Writing address 5 (OD_OFF) clears them. The status reads back at address 6.
- R8: A line not in open-drain mode has `pad_oe` = 1 and `pad_out` equal to its data bit.
- R9: A line in open-drain mode has `pad_out` = 0 and `pad_oe` equal to the inverse of its data bit.
- R10: Address 7 (PIN) reads `pad_in` through two register stages: a change on `pad_in` is visible after the second clock edge that follows it.
- R11: When a direct write, a set and a clear land in the same cycle, they apply in this order: the masked direct write first, then the set, then the clear.
- R12: Reads of the write-only addresses 1, 2, 4 and 5 return 0. A write to the read-only addresses 3, 6 and 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_we | input | 1 | Set-lane strobe |
| set_data | input | 32 | Bits to set |
| clr_we | input | 1 | Clear-lane strobe |
| clr_data | input | 32 | Bits to clear |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pad_in | input | 32 | Level seen on the pads |
| pad_out | output | 32 | Pad drive value |
| pad_oe | output | 32 | Pad drive enable |

## Verification
The bench drives a set and a clear to overlapping bits in the same cycle. A design where set wins leaves a 1 on those bits.

It issues a direct write with the permission mask cleared, and again with a partial mask. A design that ignores the mask overwrites protected pins.

A combined direct, set and clear cycle checks the three-way ordering. An open-drain line holding 1 must release the pad: a design that drives it high shows `pad_oe` set on that line.

The pin-level readback is sampled one edge and two edges after a pad change. This catches a synchronizer with one stage too few or too many.

// File: rtl/odr_pkg.sv
package odr_pkg;

    localparam int LINES  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA   = 3'd0,
        SEL_WM_ON  = 3'd1,
        SEL_WM_OFF = 3'd2,
        SEL_WM_ST  = 3'd3,
        SEL_OD_ON  = 3'd4,
        SEL_OD_OFF = 3'd5,
        SEL_OD_ST  = 3'd6,
        SEL_PIN    = 3'd7
    } reg_sel_e;

    // Order of application: masked direct write, then set, then clear.
    function automatic logic [LINES-1:0] next_level(
        input logic [LINES-1:0] cur,
        input logic             dir_we,
        input logic [LINES-1:0] dir_val,
        input logic [LINES-1:0] perm,
        input logic             s_we,
        input logic [LINES-1:0] s_bits,
        input logic             c_we,
        input logic [LINES-1:0] c_bits
    );
        logic [LINES-1:0] v;
        v = cur;
        if (dir_we) v = (v & ~perm) | (dir_val & perm);
        if (s_we)   v = v | s_bits;
        if (c_we)   v = v & ~c_bits;
        return v;
    endfunction

endpackage

// File: rtl/odr_enset_reg.sv
module odr_enset_reg #(
    parameter int                 W       = odr_pkg::LINES,
    parameter odr_pkg::reg_sel_e  ON_SEL  = odr_pkg::SEL_WM_ON,
    parameter odr_pkg::reg_sel_e  OFF_SEL = odr_pkg::SEL_WM_OFF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [odr_pkg::ADDR_W-1:0] addr,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               stat
);
    logic hit_on, hit_off;

    assign hit_on  = we && (addr == ON_SEL);
    assign hit_off = we && (addr == OFF_SEL);

    always_ff @(posedge clk) begin
        if (rst)          stat <= '0;
        else if (hit_on)  stat <= stat | wdata;
        else if (hit_off) stat <= stat & ~wdata;
    end
endmodule

// File: rtl/odr_data.sv
module odr_data #(
    parameter int W = odr_pkg::LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_we,
    input  logic [W-1:0] dir_val,
    input  logic [W-1:0] perm,
    input  logic         s_we,
    input  logic [W-1:0] s_bits,
    input  logic         c_we,
    input  logic [W-1:0] c_bits,
    output logic [W-1:0] level
);
    always_ff @(posedge clk) begin
        if (rst) level <= '0;
        else     level <= odr_pkg::next_level(level, dir_we, dir_val, perm,
                                              s_we, s_bits, c_we, c_bits);
    end
endmodule

// File: rtl/odr_pad.sv
module odr_pad #(
    parameter int W         = odr_pkg::LINES,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] od,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pin_lvl
);
    logic [W-1:0] sync_q [SYNC_DEPTH];

    for (genvar i = 0; i < W; i++) begin : g_line
        always_comb begin
            if (od[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = ~level[i];
            end else begin
                pad_out[i] = level[i];
                pad_oe[i]  = 1'b1;
            end
        end
    end

    for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)         sync_q[s] <= '0;
            else if (s == 0) sync_q[s] <= pad_in;
            else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
        end
    end

    assign pin_lvl = sync_q[SYNC_DEPTH-1];
endmodule

// File: rtl/odr_bank.sv
module odr_bank #(
    parameter int W = odr_pkg::LINES
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       set_we,
    input  logic [W-1:0]               set_data,
    input  logic                       clr_we,
    input  logic [W-1:0]               clr_data,
    input  logic                       reg_we,
    input  logic [odr_pkg::ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]               reg_wdata,
    output logic [W-1:0]               reg_rdata,
    input  logic [W-1:0]               pad_in,
    output logic [W-1:0]               pad_out,
    output logic [W-1:0]               pad_oe
);
    import odr_pkg::*;

    logic [W-1:0] data_q, wm_q, od_q, pin_q;
    logic         dir_we;

    assign dir_we = reg_we && (reg_addr == SEL_DATA);

    odr_enset_reg #(.W(W), .ON_SEL(SEL_WM_ON), .OFF_SEL(SEL_WM_OFF)) u_wmask (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .stat(wm_q)
    );

    odr_enset_reg #(.W(W), .ON_SEL(SEL_OD_ON), .OFF_SEL(SEL_OD_OFF)) u_odrain (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .stat(od_q)
    );

    odr_data #(.W(W)) u_data (
        .clk(clk), .rst(rst), .dir_we(dir_we), .dir_val(reg_wdata),
        .perm(wm_q), .s_we(set_we), .s_bits(set_data),
        .c_we(clr_we), .c_bits(clr_data), .level(data_q)
    );

    odr_pad #(.W(W), .SYNC_DEPTH(2)) u_pad (
        .clk(clk), .rst(rst), .level(data_q), .od(od_q), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_lvl(pin_q)
    );

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            SEL_DATA:  reg_rdata = data_q;
            SEL_WM_ST: reg_rdata = wm_q;
            SEL_OD_ST: reg_rdata = od_q;
            SEL_PIN:   reg_rdata = pin_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/odr_bank_chk.sv
module odr_bank_chk #(
    parameter int W = odr_pkg::LINES
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       set_we,
    input logic [W-1:0]               set_data,
    input logic                       clr_we,
    input logic [W-1:0]               clr_data,
    input logic                       reg_we,
    input logic [odr_pkg::ADDR_W-1:0] reg_addr,
    input logic [W-1:0]               pad_in,
    input logic [W-1:0]               pad_out,
    input logic [W-1:0]               pad_oe,
    input logic [W-1:0]               data_q,
    input logic [W-1:0]               wm_q,
    input logic [W-1:0]               od_q,
    input logic [W-1:0]               pin_q
);
    logic [1:0] up_cnt;

    always_ff @(posedge clk) begin
        if (rst)              up_cnt <= '0;
        else if (up_cnt != 3) up_cnt <= up_cnt + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (data_q == '0 && wm_q == '0 && od_q == '0));

    // R2
    set_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (set_we && !clr_we) |=> ((data_q & $past(set_data)) == $past(set_data)));

    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((data_q & $past(clr_data)) == '0));

    // R5
    masked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == odr_pkg::SEL_DATA && !set_we && !clr_we)
        |=> ((data_q & ~$past(wm_q)) == ($past(data_q) & ~$past(wm_q))));

    // R9
    od_no_high_chk: assert property (@(posedge clk) disable iff (rst)
        ((od_q & pad_oe & pad_out) == '0));

    // R8
    push_pull_chk: assert property (@(posedge clk) disable iff (rst)
        ((~od_q & (pad_out ^ data_q)) == '0 && (~od_q & ~pad_oe) == '0));

    // R10
    pin_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (up_cnt == 3) |-> (pin_q == $past(pad_in, 2)));
endmodule

bind odr_bank odr_bank_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data), .reg_we(reg_we),
    .reg_addr(reg_addr), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .data_q(data_q), .wm_q(wm_q), .od_q(od_q),
    .pin_q(pin_q)
);

// File: tb/test_odr_bank.sv
module test_odr_bank;
    import odr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_we = 1'b0, clr_we = 1'b0, reg_we = 1'b0;
    logic [31:0] set_data = '0, clr_data = '0, reg_wdata = '0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_rdata, pad_in, pad_out, pad_oe;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    // Pads: driven lines follow pad_out, released lines are pulled high.
    assign pad_in = (pad_oe & pad_out) | ~pad_oe;

    odr_bank i_odr_bank (
        .clk(clk), .rst(rst), .set_we(set_we), .set_data(set_data),
        .clr_we(clr_we), .clr_data(clr_data), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic lanes(input logic sw, input logic [31:0] sd,
                         input logic cw, input logic [31:0] cd);
        @(negedge clk);
        set_we = sw; set_data = sd; clr_we = cw; clr_data = cd;
        @(negedge clk);
        set_we = 1'b0; clr_we = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rd_chk("R1 data", SEL_DATA, 32'h0);
        rd_chk("R1 mask", SEL_WM_ST, 32'h0);
        rd_chk("R1 od", SEL_OD_ST, 32'h0);
        check("R1 pad_oe", pad_oe, 32'hFFFF_FFFF);
        check("R1 pad_out", pad_out, 32'h0);
    endtask

    task automatic t_set_clear();
        lanes(1'b1, 32'hF0F0_00FF, 1'b0, 32'h0);
        rd_chk("R2 set", SEL_DATA, 32'hF0F0_00FF);
        lanes(1'b0, 32'h0, 1'b1, 32'h0000_000F);
        rd_chk("R3 clear", SEL_DATA, 32'hF0F0_00F0);
        check("R8 push-pull out", pad_out, 32'hF0F0_00F0);
    endtask

    task automatic t_conflict();
        lanes(1'b1, 32'h0000_FF00, 1'b1, 32'h0000_0F00);
        rd_chk("R4 clear wins", SEL_DATA, 32'hF0F0_F0F0);
    endtask

    task automatic t_masked();
        reg_wr(SEL_DATA, 32'hFFFF_FFFF);
        rd_chk("R5 no mask", SEL_DATA, 32'hF0F0_F0F0);
        reg_wr(SEL_WM_ON, 32'h0000_FFFF);
        rd_chk("R6 mask on", SEL_WM_ST, 32'h0000_FFFF);
        reg_wr(SEL_WM_OFF, 32'h0000_00F0);
        rd_chk("R6 mask off", SEL_WM_ST, 32'h0000_FF0F);
        reg_wr(SEL_DATA, 32'h1234_5678);
        rd_chk("R5 masked write", SEL_DATA, 32'hF0F0_56F8);
    endtask

    task automatic t_priority();
        @(negedge clk);
        reg_we = 1'b1; reg_addr = SEL_DATA; reg_wdata = 32'hFFFF_FFFF;
        set_we = 1'b1; set_data = 32'h0001_0000;
        clr_we = 1'b1; clr_data = 32'h0000_000F;
        @(negedge clk);
        reg_we = 1'b0; set_we = 1'b0; clr_we = 1'b0;
        rd_chk("R11 order", SEL_DATA, 32'hF0F1_FFF0);
    endtask

    task automatic t_access();
        rd_chk("R12 wm_on reads 0", SEL_WM_ON, 32'h0);
        rd_chk("R12 od_off reads 0", SEL_OD_OFF, 32'h0);
        reg_wr(SEL_PIN, 32'hFFFF_FFFF);
        reg_wr(SEL_WM_ST, 32'hFFFF_FFFF);
        rd_chk("R12 data kept", SEL_DATA, 32'hF0F1_FFF0);
        rd_chk("R12 mask kept", SEL_WM_ST, 32'h0000_FF0F);
    endtask

    task automatic t_open_drain();
        reg_wr(SEL_OD_ON, 32'h0000_00FF);
        rd_chk("R7 od on", SEL_OD_ST, 32'h0000_00FF);
        check("R9 od oe", pad_oe, 32'hFFFF_FF0F);
        check("R9 od out", pad_out, 32'hF0F1_FF00);
        reg_wr(SEL_OD_OFF, 32'h0000_000F);
        rd_chk("R7 od off", SEL_OD_ST, 32'h0000_00F0);
        check("R8 upper lines", pad_out & 32'hFFFF_FF00, 32'hF0F1_FF00);
    endtask

    task automatic t_pin();
        repeat (3) @(negedge clk);
        rd_chk("R10 steady", SEL_PIN, 32'hF0F1_FFF0);
        @(negedge clk);
        clr_we = 1'b1; clr_data = 32'h8000_0000;
        @(negedge clk);
        clr_we = 1'b0;
        rd_chk("R10 edge+1 old", SEL_PIN, 32'hF0F1_FFF0);
        @(negedge clk);
        rd_chk("R10 edge+2 old", SEL_PIN, 32'hF0F1_FFF0);
        @(negedge clk);
        rd_chk("R10 edge+3 new", SEL_PIN, 32'h70F1_FFF0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_clear();
        t_conflict();
        t_masked();
        t_priority();
        t_access();
        t_open_drain();
        t_pin();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule